// File: doc/BRIEF.md
# Branch Direction Predictor with Static and Table Modes

This block guesses whether a conditional branch will be taken, for an in-order fetch pipeline. Each lookup presents the fetch address of the branch and its signed displacement field. One cycle later the block returns a taken or not-taken guess. A mode input chooses the source of that guess on every lookup. In static mode a backward branch (negative displacement) is guessed taken. In dynamic mode the guess is read from a history table indexed by low fetch-address bits.

A separate resolve port reports the real outcome of a branch and the guess that was used for it. That report trains the history table in either mode. It also raises a one-cycle mispredict flag, so that downstream logic can charge the four-cycle penalty. A build parameter picks the table flavour: 2048 one-bit entries, or 4096 two-bit saturating counters.

Top module: `bdir_predictor`

## Requirements
- R1: While reset is low, and in the cycle after it rises, pred_valid_o and mispredict_o are 0. Reset clears every table entry to 0 for one-bit entries and to 01 (weakly not taken) for two-bit entries, so every dynamic lookup before any resolve predicts not taken.
- R2: pred_valid_o is 1 in the cycle after a cycle with lkp_valid_i high, and 0 otherwise.
- R3: When mode_dyn_i is 0 at lookup, pred_taken_o equals the most significant bit of lkp_disp_i (1 = backward = taken).
- R4: With CTR_BITS=1 and mode_dyn_i at 1, the entry index is pc[12:2]; address bits outside that slice have no effect. An entry of 1 predicts taken, and a resolve overwrites the entry with res_taken_i.
- R5: With CTR_BITS=2 and mode_dyn_i at 1, the index is pc[13:2] and the entry is a counter that counts up on taken and down on not taken. It saturates at 3 and at 0, and its upper bit is the prediction.
- R6: A lookup and a resolve that map to the same entry in the same cycle return the entry value held before that resolve.
- R7: mispredict_o is 1 in the cycle after a cycle with res_valid_i high and res_taken_i different from res_pred_i, and 0 otherwise.
- R8: Resolves train the table whatever the mode, and the mode only selects the source of the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_dyn_i | input | 1 | 0 = sign rule, 1 = history table |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_pc_i | input | ADDR_W | Fetch address of the branch |
| lkp_disp_i | input | DISP_W | Signed displacement field |
| res_valid_i | input | 1 | Resolve report |
| res_pc_i | input | ADDR_W | Fetch address of the resolved branch |
| res_taken_i | input | 1 | Actual outcome |
| res_pred_i | input | 1 | Guess that was used for this branch |
| pred_valid_o | output | 1 | Prediction valid, one cycle after lookup |
| pred_taken_o | output | 1 | Predicted direction |
| mispredict_o | output | 1 | Guess differed from outcome, one cycle after resolve |

## Verification
A corrupted or mis-indexed table entry shows up only as a wrong pred_taken_o on the first dynamic lookup that reaches that entry. It appears one cycle after that lookup. For that reason the bench sweeps every index after reset and again after training. A counter that fails to saturate or wraps shows up as a flipped guess after a run of equal outcomes followed by one opposite outcome. An ordering error between a read and a write to the same entry shows up in that same cycle's prediction. A wrong mispredict flag is visible in the cycle right after the resolve.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef enum logic {
    SRC_SIGN  = 1'b0,
    SRC_TABLE = 1'b1
  } pred_src_e;

  function automatic int idx_bits(input int ctr_bits);
    return (ctr_bits == 1) ? 11 : 12;
  endfunction
endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 11
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o
);
  // word offset dropped, upper bits alias
  assign idx_o = pc_i[IDX_W+1:2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[ADDR_W-1:IDX_W+2], pc_i[1:0]};
endmodule

// File: rtl/bdp_ctr_next.sv
module bdp_ctr_next #(
  parameter int CTR_BITS = 1
) (
  input  logic [CTR_BITS-1:0] ctr_i,
  input  logic                taken_i,
  output logic [CTR_BITS-1:0] ctr_o
);
  localparam logic [CTR_BITS-1:0] CMAX = '1;
  localparam logic [CTR_BITS-1:0] CMIN = '0;

  generate
    if (CTR_BITS == 1) begin : g_last_outcome
      assign ctr_o = taken_i;
    end else begin : g_saturating
      always_comb begin
        if (taken_i) ctr_o = (ctr_i == CMAX) ? CMAX : ctr_i + 1'b1;
        else         ctr_o = (ctr_i == CMIN) ? CMIN : ctr_i - 1'b1;
      end

      always_comb begin
        a_r5_sat_top: assert (!(taken_i && ctr_i == CMAX) || ctr_o == CMAX);
        a_r5_sat_bottom: assert (!(!taken_i && ctr_i == CMIN) || ctr_o == CMIN);
      end
    end
  endgenerate
endmodule

// File: rtl/bdp_table.sv
module bdp_table #(
  parameter int CTR_BITS = 1,
  parameter int IDX_W    = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [CTR_BITS-1:0] rd_ctr_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_BITS-1:0] RST_VAL = (CTR_BITS == 2) ? CTR_BITS'(1) : '0;

  logic [CTR_BITS-1:0] mem_q [DEPTH];
  logic [CTR_BITS-1:0] wr_next;

  bdp_ctr_next #(.CTR_BITS(CTR_BITS)) u_next (
    .ctr_i  (mem_q[wr_idx_i]),
    .taken_i(wr_taken_i),
    .ctr_o  (wr_next)
  );

  // read is combinational; caller registers it, so a same-edge write is not seen
  assign rd_ctr_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_next;
    end
  end

  generate
    if (CTR_BITS == 1) begin : g_chk1
      a_r4_entry_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_taken_i));
    end else begin : g_chk2
      a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (mem_q[$past(wr_idx_i)] - $past(mem_q[wr_idx_i])) inside
                    {CTR_BITS'(0), CTR_BITS'(1), '1});
    end
  endgenerate
endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
  import bdp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 21,
  parameter int CTR_BITS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_dyn_i,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  input  logic [DISP_W-1:0] lkp_disp_i,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic              res_taken_i,
  input  logic              res_pred_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              mispredict_o
);
  localparam int IDX_W = idx_bits(CTR_BITS);

  logic [IDX_W-1:0]    lkp_idx, res_idx;
  logic [CTR_BITS-1:0] lkp_ctr;
  pred_src_e           src;
  logic                guess;
  logic                pred_valid_q, pred_taken_q, mispredict_q;

  bdp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lkp_idx (
    .pc_i (lkp_pc_i),
    .idx_o(lkp_idx)
  );

  bdp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_res_idx (
    .pc_i (res_pc_i),
    .idx_o(res_idx)
  );

  bdp_table #(.CTR_BITS(CTR_BITS), .IDX_W(IDX_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lkp_idx),
    .rd_ctr_o  (lkp_ctr),
    .wr_en_i   (res_valid_i),
    .wr_idx_i  (res_idx),
    .wr_taken_i(res_taken_i)
  );

  assign src   = pred_src_e'(mode_dyn_i);
  assign guess = (src == SRC_TABLE) ? lkp_ctr[CTR_BITS-1] : lkp_disp_i[DISP_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q <= 1'b0;
      pred_taken_q <= 1'b0;
      mispredict_q <= 1'b0;
    end else begin
      pred_valid_q <= lkp_valid_i;
      if (lkp_valid_i) pred_taken_q <= guess;
      mispredict_q <= res_valid_i && (res_taken_i != res_pred_i);
    end
  end

  assign pred_valid_o = pred_valid_q;
  assign pred_taken_o = pred_taken_q;
  assign mispredict_o = mispredict_q;

  logic unused_disp_bits;
  assign unused_disp_bits = ^lkp_disp_i[DISP_W-2:0];

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> pred_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !pred_valid_o);
  a_r3_sign_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !mode_dyn_i) |=> pred_taken_o == $past(lkp_disp_i[DISP_W-1]));
  a_r7_flag_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_taken_i != res_pred_i) |=> mispredict_o);
  a_r7_quiet_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i || res_taken_i == res_pred_i) |=> !mispredict_o);
  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> $stable(pred_taken_o));
endmodule

// File: tb/bdir_predictor_test.sv
`timescale 1ns/1ps
module bdir_predictor_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_dyn, lv, rv, rt, rp;
  logic [31:0] lpc, rpc;
  logic [20:0] disp;
  logic        pv1, pt1, mp1, pv2, pt2, mp2;

  int n_chk = 0;
  int n_bad = 0;
  bit          ref1 [2048];
  logic [1:0]  ref2 [4096];
  logic [31:0] rng = 32'h1234_5679;

  always #10 clk = ~clk;

  bdir_predictor #(.CTR_BITS(1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_dyn_i(mode_dyn), .lkp_valid_i(lv),
    .lkp_pc_i(lpc), .lkp_disp_i(disp), .res_valid_i(rv), .res_pc_i(rpc),
    .res_taken_i(rt), .res_pred_i(rp), .pred_valid_o(pv1), .pred_taken_o(pt1),
    .mispredict_o(mp1));

  bdir_predictor #(.CTR_BITS(2)) uut_sat (
    .clk_i(clk), .rst_ni(rst_ni), .mode_dyn_i(mode_dyn), .lkp_valid_i(lv),
    .lkp_pc_i(lpc), .lkp_disp_i(disp), .res_valid_i(rv), .res_pc_i(rpc),
    .res_taken_i(rt), .res_pred_i(rp), .pred_valid_o(pv2), .pred_taken_o(pt2),
    .mispredict_o(mp2));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clear_ref();
    for (int i = 0; i < 2048; i++) ref1[i] = 1'b0;
    for (int i = 0; i < 4096; i++) ref2[i] = 2'b01;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; lv = 0; rv = 0; rt = 0; rp = 0; mode_dyn = 0;
    lpc = '0; rpc = '0; disp = '0;
    clear_ref();
    #1;
    chk("R1", "valid in reset", pv1 | pv2, 1'b0);
    chk("R1", "mispredict in reset", mp1 | mp2, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", pv1 | pv2, 1'b0);
    chk("R1", "mispredict after reset", mp1 | mp2, 1'b0);
  endtask

  // one cycle: drive at negedge, model, check at next negedge
  task automatic cyc(input string tag, input logic l_v, input logic [31:0] l_pc,
                     input logic [20:0] l_d, input logic md, input logic r_v,
                     input logic [31:0] r_pc, input logic r_t, input logic r_p);
    logic e1, e2, em;
    lv = l_v; lpc = l_pc; disp = l_d; mode_dyn = md;
    rv = r_v; rpc = r_pc; rt = r_t; rp = r_p;
    e1 = md ? ref1[l_pc[12:2]]    : l_d[20];
    e2 = md ? ref2[l_pc[13:2]][1] : l_d[20];
    em = r_v && (r_t != r_p);
    if (r_v) begin
      ref1[r_pc[12:2]] = r_t;
      if (r_t) ref2[r_pc[13:2]] = (ref2[r_pc[13:2]] == 2'b11) ? 2'b11 : ref2[r_pc[13:2]] + 2'b01;
      else     ref2[r_pc[13:2]] = (ref2[r_pc[13:2]] == 2'b00) ? 2'b00 : ref2[r_pc[13:2]] - 2'b01;
    end
    @(negedge clk);
    chk("R2", "valid 1-bit", pv1, l_v);
    chk("R2", "valid 2-bit", pv2, l_v);
    if (l_v) begin
      chk(md ? "R4" : "R3", {tag, " pred 1-bit"}, pt1, e1);
      chk(md ? "R5" : "R3", {tag, " pred 2-bit"}, pt2, e2);
    end
    chk("R7", "mispredict 1-bit", mp1, em);
    chk("R7", "mispredict 2-bit", mp2, em);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 4096; i++)
      cyc(tag, 1'b1, 32'(i) << 2, 21'h0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20ns * 190000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    lv = 0; rv = 0; rt = 0; rp = 0; mode_dyn = 0; lpc = '0; rpc = '0; disp = '0;
    do_reset();

    // R1: all entries not taken after reset
    sweep("R1 cleared");

    // R3: sign rule over assorted displacements
    cyc("R3", 1'b1, 32'h40, 21'h000000, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    cyc("R3", 1'b1, 32'h40, 21'h0FFFFF, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    cyc("R3", 1'b1, 32'h40, 21'h100000, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    cyc("R3", 1'b1, 32'h40, 21'h1FFFFF, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 64; i++) begin
      rng = nxt(rng);
      cyc("R3", 1'b1, rng, rng[30:10], 1'b0, 1'b0, '0, 1'b0, 1'b0);
    end

    // R8: training while in static mode, then read back dynamically (R4 R5)
    for (int i = 0; i < 4096; i++)
      cyc("R8", 1'b0, '0, '0, 1'b0, 1'b1, 32'(i) << 2, 1'((i * 7) ^ (i >> 3)), 1'b0);
    sweep("R8 trained");
    for (int i = 0; i < 4096; i++)
      cyc("R8", 1'b0, '0, '0, 1'b1, 1'b1, 32'(i) << 2, 1'((i * 7) ^ (i >> 3)), 1'b1);
    sweep("R5 second");

    // R5: saturation and hysteresis at one address
    for (int k = 0; k < 5; k++)
      cyc("R5 up", 1'b1, 32'h0000_1230, '0, 1'b1, 1'b1, 32'h0000_1230, 1'b1, 1'b1);
    cyc("R5 one miss", 1'b1, 32'h0000_1230, '0, 1'b1, 1'b1, 32'h0000_1230, 1'b0, 1'b1);
    cyc("R5 hold", 1'b1, 32'h0000_1230, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++)
      cyc("R5 down", 1'b1, 32'h0000_1230, '0, 1'b1, 1'b1, 32'h0000_1230, 1'b0, 1'b0);
    cyc("R5 floor", 1'b1, 32'h0000_1230, '0, 1'b1, 1'b1, 32'h0000_1230, 1'b1, 1'b0);
    cyc("R5 floor", 1'b1, 32'h0000_1230, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    // R6: same-entry lookup and resolve; R4 aliasing via upper address bits
    cyc("R6", 1'b1, 32'h0000_0884, '0, 1'b1, 1'b1, 32'h0000_0884, 1'b1, 1'b0);
    cyc("R6", 1'b1, 32'hFFFF_0884, '0, 1'b1, 1'b1, 32'h0000_0886, 1'b0, 1'b1);
    cyc("R4 alias", 1'b1, 32'h8000_2887, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    // R4 R5 R6 R7: random traffic incl. same-index collisions
    for (int i = 0; i < 30000; i++) begin
      logic [31:0] a, b;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); b = rng[7] ? a : rng;
      rng = nxt(rng);
      cyc("R6 mix", rng[0], a, rng[31:11], rng[1], rng[2], b, rng[3], rng[4]);
    end

    // R1: mid-run reset clears the table
    do_reset();
    sweep("R1 re-cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule